// File: doc/BRIEF.md
# Interrupt Vector Priority Tracker

This block keeps three 256-entry bitmaps for a local interrupt controller: pending requests, vectors in service, and the trigger mode recorded for each vector. From the task priority value and the highest vector in service it forms the processor priority. It presents the highest pending vector as deliverable only when that vector's 16-vector class is strictly above the processor priority.

Fixed-mode requests arrive on a request port. The block answers each one in the same cycle, saying whether it was accepted. An acknowledge strobe moves the deliverable vector from pending to in service. An end-of-interrupt strobe retires the highest in-service vector and emits a notice that carries the vector number and its recorded trigger mode. The notice is withheld when the directed-EOI control is set. The block operates only while both the hardware-enable and software-enable controls are high.

Top module: `vec_prio_tracker`

## Requirements
- R1: Reset clears every pending, in-service and trigger-mode bit and sets the task priority to 0, so that after reset `dlv_valid` is 0 and `ppr` is 0.
- R2: Vector v is held as bit v[4:0] of 32-bit word v[7:5]. The vector offered on `dlv_vec` is the highest pending vector number, found from word 7 down to word 0.
- R3: Let ISRV be the highest in-service vector, or 0 when none is in service. If TPR[7:4] >= ISRV[7:4], then `ppr` = TPR[7:0]. Otherwise `ppr` = {ISRV[7:4], 4'h0}. `ppr` follows every TPR write, acknowledge and EOI in the next cycle.
- R4: `dlv_valid` is 1 only when the block is enabled, some vector is pending, and (highest pending & 8'hF0) > `ppr`. When `dlv_valid` is 0, `dlv_vec` reads 0.
- R5: The block is enabled only when `hw_en` and `sw_en` are both 1. A request that arrives while the block is disabled is dropped, and `req_accept` is 0.
- R6: A request for a vector that is already pending is merged with it. `req_accept` is 0 and the recorded trigger mode is left unchanged.
- R7: A newly accepted request records level mode when `req_level` is 1 and edge mode when it is 0.
- R8: `ack` with `dlv_valid` high marks the offered vector in service and clears it from pending. `ack` with `dlv_valid` low has no effect.
- R9: `eoi` clears the highest in-service vector. With nothing in service it changes nothing and no notice is raised.
- R10: In the cycle of an effective `eoi`, `eoi_note_valid` is 1, `eoi_note_vec` is the retired vector, and `eoi_note_level` is its recorded mode (1 = level). The recorded mode is then cleared. When `dir_eoi` is 1 the notice is withheld. The notice fields read 0 whenever no notice is raised.
- R11: A TPR write keeps `tpr_wdata[7:0]` and discards the upper bits.
- R12: When a request and an acknowledge occur in the same cycle, both act on the pending state from before that cycle. The acknowledge takes the previously deliverable vector, and the new request is accepted or merged against the old pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| dir_eoi | input | 1 | Withhold the EOI notice when 1 |
| req_valid | input | 1 | Fixed-mode request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered request |
| req_accept | output | 1 | Request newly recorded this cycle |
| ack | input | 1 | Acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write enable |
| tpr_wdata | input | 32 | Task priority write data |
| dlv_valid | output | 1 | A vector may be delivered |
| dlv_vec | output | 8 | Deliverable vector |
| ppr | output | 8 | Processor priority |
| eoi_note_valid | output | 1 | EOI notice strobe |
| eoi_note_vec | output | 8 | Retired vector |
| eoi_note_level | output | 1 | Retired vector was level-triggered |

## Verification
The bench targets class-boundary cases: a task priority whose class equals the pending class must block delivery, and one just below it must allow delivery. A design that used >= would offer the vector one class too early. The bench merges a level request into a pending edge request and checks that the EOI notice still reports edge; a design that rewrote the trigger bit on a merge would report level. A request and an acknowledge in the same cycle show whether the acknowledge grabs the newly arriving vector. An EOI with an empty in-service set, and an acknowledge while nothing is deliverable, expose designs that raise a stray notice or move a blocked vector into service.

// File: rtl/vpt_pkg.sv
`timescale 1ns/1ps
package vpt_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int PRIO_W = 8;

  // Index of the highest set bit of one bitmap word (0 when empty).
  function automatic logic [IDX_W-1:0] word_msb(input logic [WORD_W-1:0] w);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int b = 0; b < WORD_W; b++)
      if (w[b]) r = IDX_W'(b);
    return r;
  endfunction

  // Processor priority from task priority and top in-service vector.
  function automatic logic [PRIO_W-1:0] ppr_of(input logic [PRIO_W-1:0] tpr,
                                               input logic [PRIO_W-1:0] isrv);
    if (tpr[7:4] >= isrv[7:4]) return tpr;
    return {isrv[7:4], 4'h0};
  endfunction

  // Class of a pending vector strictly above the priority.
  function automatic logic class_above(input logic [PRIO_W-1:0] vec,
                                       input logic [PRIO_W-1:0] prio);
    return {vec[7:4], 4'h0} > prio;
  endfunction
endpackage

// File: rtl/vpt_find_highest.sv
`timescale 1ns/1ps
module vpt_find_highest #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] bits,
  output logic               found,
  output logic [VEC_W-1:0]   top
);
  import vpt_pkg::*;
  localparam int NWORDS = NUM_VEC / WORD_W;

  logic [NWORDS-1:0]    word_any;
  logic [IDX_W-1:0]     word_hi [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign word_any[w] = |bits[w*WORD_W +: WORD_W];
    assign word_hi[w]  = word_msb(bits[w*WORD_W +: WORD_W]);
  end

  // Later (higher) words override earlier ones.
  always_comb begin
    found = 1'b0;
    top   = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (word_any[w]) begin
        found = 1'b1;
        top   = VEC_W'(w * WORD_W) + VEC_W'(word_hi[w]);
      end
    end
  end
endmodule

// File: rtl/vpt_ppr_calc.sv
`timescale 1ns/1ps
module vpt_ppr_calc (
  input  logic       isr_found,
  input  logic [7:0] isr_top,
  input  logic [7:0] tpr,
  output logic [7:0] ppr
);
  import vpt_pkg::*;
  logic [7:0] isrv;
  assign isrv = isr_found ? isr_top : 8'h00;
  assign ppr  = ppr_of(tpr, isrv);
endmodule

// File: rtl/vpt_deliver_gate.sv
`timescale 1ns/1ps
module vpt_deliver_gate (
  input  logic       enabled,
  input  logic       irr_found,
  input  logic [7:0] irr_top,
  input  logic [7:0] ppr,
  output logic       dlv_valid,
  output logic [7:0] dlv_vec
);
  import vpt_pkg::*;
  assign dlv_valid = enabled && irr_found && class_above(irr_top, ppr);
  assign dlv_vec   = dlv_valid ? irr_top : 8'h00;
endmodule

// File: rtl/vec_prio_tracker.sv
`timescale 1ns/1ps
module vec_prio_tracker #(
  parameter int NUM_VEC = 256,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic             sw_en,
  input  logic             dir_eoi,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vec,
  input  logic             req_level,
  output logic             req_accept,
  input  logic             ack,
  input  logic             eoi,
  input  logic             tpr_we,
  input  logic [31:0]      tpr_wdata,
  output logic             dlv_valid,
  output logic [VEC_W-1:0] dlv_vec,
  output logic [7:0]       ppr,
  output logic             eoi_note_valid,
  output logic [VEC_W-1:0] eoi_note_vec,
  output logic             eoi_note_level
);
  logic [NUM_VEC-1:0] irr_q, irr_d;
  logic [NUM_VEC-1:0] isr_q, isr_d;
  logic [NUM_VEC-1:0] tmr_q, tmr_d;
  logic [7:0]         tpr_q;

  // Named internal events for the checker.
  logic             enabled;
  logic             irr_found, isr_found;
  logic [VEC_W-1:0] irr_top, isr_top;
  logic             ack_fire, eoi_fire;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^tpr_wdata[31:8];
  assign enabled         = hw_en & sw_en;

  vpt_find_highest #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) i_irr_search (
    .bits(irr_q), .found(irr_found), .top(irr_top));

  vpt_find_highest #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) i_isr_search (
    .bits(isr_q), .found(isr_found), .top(isr_top));

  vpt_ppr_calc i_ppr (
    .isr_found(isr_found), .isr_top(isr_top), .tpr(tpr_q), .ppr(ppr));

  vpt_deliver_gate i_gate (
    .enabled(enabled), .irr_found(irr_found), .irr_top(irr_top),
    .ppr(ppr), .dlv_valid(dlv_valid), .dlv_vec(dlv_vec));

  // Requests and acknowledges both see the pending state of this cycle.
  assign req_accept = req_valid & enabled & ~irr_q[req_vec];
  assign ack_fire   = ack & dlv_valid;
  assign eoi_fire   = eoi & isr_found;

  assign eoi_note_valid = eoi_fire & ~dir_eoi;
  assign eoi_note_vec   = eoi_note_valid ? isr_top : '0;
  assign eoi_note_level = eoi_note_valid & tmr_q[isr_top];

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack_fire) begin
      irr_d[dlv_vec] = 1'b0;
      isr_d[dlv_vec] = 1'b1;
    end
    if (eoi_fire) begin
      isr_d[isr_top] = 1'b0;
      tmr_d[isr_top] = 1'b0;
    end
    // A fresh request's trigger mode wins over a same-cycle retire.
    if (req_accept) begin
      irr_d[req_vec] = 1'b1;
      tmr_d[req_vec] = req_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
      tpr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
      if (tpr_we) tpr_q <= tpr_wdata[7:0];
    end
  end
endmodule

// File: rtl/vpt_checker.sv
`timescale 1ns/1ps
module vpt_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         hw_en,
  input logic         sw_en,
  input logic         dir_eoi,
  input logic         req_valid,
  input logic [7:0]   req_vec,
  input logic         req_level,
  input logic         req_accept,
  input logic         ack,
  input logic         eoi,
  input logic         dlv_valid,
  input logic [7:0]   dlv_vec,
  input logic [7:0]   ppr,
  input logic [7:0]   tpr_q,
  input logic         eoi_note_valid,
  input logic [255:0] irr_q,
  input logic [255:0] isr_q,
  input logic [255:0] tmr_q,
  input logic         isr_found,
  input logic [7:0]   isr_top
);
  AST_PPR_NOT_BELOW_TPR: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_q); // R3
  AST_DLV_ABOVE_PPR: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> ({dlv_vec[7:4], 4'h0} > ppr) && irr_q[dlv_vec]); // R4
  AST_ACCEPT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> hw_en && sw_en); // R5
  AST_DISABLED_NO_DLV: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_en && sw_en) |-> !dlv_valid); // R5
  AST_MERGE_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && irr_q[req_vec] |-> !req_accept); // R6
  AST_TMR_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> tmr_q[$past(req_vec)] == $past(req_level)); // R7
  AST_ACK_MOVES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    ack && dlv_valid |=> isr_q[$past(dlv_vec)] && !irr_q[$past(dlv_vec)]); // R8
  AST_EOI_RETIRES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && isr_found |=> !isr_q[$past(isr_top)]); // R9
  AST_NOTE_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
    dir_eoi |-> !eoi_note_valid); // R10
endmodule

bind vec_prio_tracker vpt_checker i_vpt_checker (
  .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en), .dir_eoi(dir_eoi),
  .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
  .req_accept(req_accept), .ack(ack), .eoi(eoi), .dlv_valid(dlv_valid),
  .dlv_vec(dlv_vec), .ppr(ppr), .tpr_q(tpr_q), .eoi_note_valid(eoi_note_valid),
  .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q), .isr_found(isr_found),
  .isr_top(isr_top));

// File: tb/test_vec_prio_tracker.sv
`timescale 1ns/1ps
module test_vec_prio_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_en, sw_en, dir_eoi, req_valid, req_level, ack, eoi, tpr_we;
  logic [7:0]  req_vec;
  logic [31:0] tpr_wdata;
  logic req_accept, dlv_valid, eoi_note_valid, eoi_note_level;
  logic [7:0] dlv_vec, ppr, eoi_note_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Behavioural reference state.
  logic [255:0] m_irr, m_isr, m_tmr;
  int m_tpr;

  always #4 clk = ~clk;

  vec_prio_tracker i_vec_prio_tracker (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int hi_of(input logic [255:0] m);
    for (int i = 255; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int m_ppr();
    int t = hi_of(m_isr);
    int isrv = (t < 0) ? 0 : t;
    if ((m_tpr >> 4) >= (isrv >> 4)) return m_tpr;
    return isrv & 'hF0;
  endfunction

  function automatic int m_dlv();
    int h = hi_of(m_irr);
    if (!(hw_en && sw_en) || h < 0) return -1;
    if ((h & 'hF0) > m_ppr()) return h;
    return -1;
  endfunction

  task automatic compare_all();
    int d = m_dlv();
    int ih = hi_of(m_isr);
    bit acc = req_valid && hw_en && sw_en && !m_irr[req_vec];
    bit nv = eoi && (ih >= 0) && !dir_eoi;
    chk("R3 ppr", ppr, m_ppr());
    chk("R4 dlv_valid", dlv_valid, d >= 0);
    chk("R2 dlv_vec", dlv_vec, (d >= 0) ? d : 0);
    chk("R6 req_accept", req_accept, acc);
    chk("R10 eoi_note_valid", eoi_note_valid, nv);
    chk("R10 eoi_note_vec", eoi_note_vec, nv ? ih : 0);
    chk("R10 eoi_note_level", eoi_note_level, nv ? m_tmr[ih] : 0);
  endtask

  task automatic model_step();
    int d = m_dlv();
    int ih = hi_of(m_isr);
    bit acc = req_valid && hw_en && sw_en && !m_irr[req_vec];
    if (ack && d >= 0) begin m_irr[d] = 0; m_isr[d] = 1; end
    if (eoi && ih >= 0) begin m_isr[ih] = 0; m_tmr[ih] = 0; end
    if (acc) begin m_irr[req_vec] = 1; m_tmr[req_vec] = req_level; end
    if (tpr_we) m_tpr = tpr_wdata & 'hFF;
  endtask

  task automatic cycle();
    @(negedge clk);
    compare_all();
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic idle();
    req_valid = 0; ack = 0; eoi = 0; tpr_we = 0;
  endtask

  task automatic req(input int v, input bit lvl);
    idle(); req_valid = 1; req_vec = 8'(v); req_level = lvl; cycle(); idle();
  endtask

  task automatic wr_tpr(input logic [31:0] d);
    idle(); tpr_we = 1; tpr_wdata = d; cycle(); idle();
  endtask

  task automatic do_ack();
    idle(); ack = 1; cycle(); idle();
  endtask

  task automatic do_eoi();
    idle(); eoi = 1; cycle(); idle();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    hw_en = 1; sw_en = 1; dir_eoi = 0; req_vec = 0; req_level = 0; tpr_wdata = 0;
    idle();
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R1 dlv_valid after reset", dlv_valid, 0);
    chk("R1 ppr after reset", ppr, 0);

    // R5: request dropped while software enable is low.
    sw_en = 0;
    req(8'h40, 0);
    sw_en = 1; #1;
    chk("R5 dropped request not pending", dlv_valid, 0);

    // R2: single pending vector is offered.
    req(8'h45, 0);
    chk("R2 dlv_valid", dlv_valid, 1);
    chk("R2 dlv_vec", dlv_vec, 8'h45);

    // R6: merge a level request into the pending edge one.
    req_valid = 1; req_vec = 8'h45; req_level = 1; #1;
    chk("R6 merged request not accepted", req_accept, 0);
    cycle(); idle();

    // R2: highest across words.
    req(8'hA3, 1);
    req(8'h21, 0);
    #1 chk("R2 highest vector across words", dlv_vec, 8'hA3);

    // R11 and R4 class boundaries.
    wr_tpr(32'hFFFF_FFB0);
    chk("R11 tpr keeps low byte", ppr, 8'hB0);
    chk("R4 blocked by higher tpr", dlv_valid, 0);
    wr_tpr(32'h0000_00A0);
    chk("R4 equal class blocks", dlv_valid, 0);
    wr_tpr(32'h0000_009F);
    chk("R4 lower tpr allows", dlv_valid, 1);
    wr_tpr(32'h0);

    // R8 and R3: acknowledge raises ppr to the in-service class.
    do_ack();
    chk("R3 ppr from in-service class", ppr, 8'hA0);
    chk("R8 lower class now blocked", dlv_valid, 0);
    do_ack(); // ignored: nothing deliverable
    chk("R8 ignored ack keeps ppr", ppr, 8'hA0);

    // R10/R7: EOI notice for level vector.
    idle(); eoi = 1; #1;
    chk("R10 notice valid", eoi_note_valid, 1);
    chk("R10 notice vector", eoi_note_vec, 8'hA3);
    chk("R7 level mode reported", eoi_note_level, 1);
    cycle(); idle();
    chk("R9 ppr after retire", ppr, 8'h00);
    chk("R8 ignored ack left vector pending", dlv_vec, 8'h45);

    // R6: merged level request did not change edge mode.
    do_ack();
    idle(); eoi = 1; #1;
    chk("R6 merge kept edge mode", eoi_note_level, 0);
    chk("R10 notice vector", eoi_note_vec, 8'h45);
    cycle(); idle();

    // R10: directed EOI withholds the notice.
    dir_eoi = 1;
    do_ack();
    chk("R3 ppr for vector 21", ppr, 8'h20);
    idle(); eoi = 1; #1;
    chk("R10 notice withheld", eoi_note_valid, 0);
    cycle(); idle();
    chk("R9 retired under directed mode", ppr, 8'h00);
    dir_eoi = 0;

    // R9: EOI with nothing in service.
    idle(); eoi = 1; #1;
    chk("R9 empty eoi no notice", eoi_note_valid, 0);
    cycle(); idle();
    chk("R9 empty eoi ppr", ppr, 8'h00);

    // R12: request and acknowledge in the same cycle.
    req(8'h80, 0);
    idle(); req_valid = 1; req_vec = 8'h90; req_level = 1; ack = 1; #1;
    chk("R12 request accepted alongside ack", req_accept, 1);
    cycle(); idle();
    chk("R12 ack took older vector", ppr, 8'h80);
    chk("R12 new vector now offered", dlv_vec, 8'h90);

    // R9: nested retire order.
    do_ack();
    chk("R3 nested ppr", ppr, 8'h90);
    idle(); eoi = 1; #1;
    chk("R9 highest retired first", eoi_note_vec, 8'h90);
    cycle(); idle();
    chk("R9 ppr back to outer", ppr, 8'h80);
    do_eoi();
    chk("R9 ppr empty", ppr, 8'h00);

    // R5: hardware enable low hides pending vectors.
    req(8'h70, 0);
    hw_en = 0; #1;
    chk("R5 hw disable hides vector", dlv_valid, 0);
    cycle();
    hw_en = 1; #1;
    chk("R5 vector back after enable", dlv_valid, 1);

    // Random phase against the reference model.
    for (int i = 0; i < 3000; i++) begin
      hw_en     = ($urandom_range(0, 19) != 0);
      sw_en     = ($urandom_range(0, 19) != 0);
      dir_eoi   = ($urandom_range(0, 4) == 0);
      req_valid = ($urandom_range(0, 9) < 4);
      req_vec   = 8'($urandom_range(16, 255));
      req_level = $urandom_range(0, 1);
      ack       = ($urandom_range(0, 9) < 3);
      eoi       = ($urandom_range(0, 9) < 2);
      tpr_we    = ($urandom_range(0, 19) == 0);
      tpr_wdata = {$urandom_range(0, 65535), 8'h00, 8'($urandom_range(0, 191))};
      cycle();
    end
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule